// File: doc/BRIEF.md
# Unrolled Successive-Cancellation Polar Decoder

This block decodes a length-16 polar code with successive cancellation. The decoder is laid out in space, not in time. Every node visit of the depth-first walk over the code tree has its own register stage, so a new frame of sixteen channel LLRs can enter on every clock. Sixteen estimated source bits leave after a fixed delay. The frozen set is fixed when the block is built: positions 0 to 6 and position 8 are frozen to zero, and positions 7 and 9 to 15 carry data.

Under that frozen set the tree breaks into four 4-leaf subtrees, and none of them is walked leaf by leaf. Leaves 0-3 are an all-frozen subtree, which is folded into its parent. Leaves 4-7 form a repetition code. Leaves 8-11 form a single-parity-check code. Leaves 12-15 are an all-data subtree, which is folded into the parent step that produces its LLRs. After pruning, the pipeline is seven stages deep, where the unpruned tree would need 61.

LLRs are signed 6-bit values. A channel LLR for code bit i sits at `in_llr[6*i +: 6]`. A non-negative LLR means bit 0.

Top module: `polar_sc_pipe`

## Requirements
- R1: A frame taken with `in_valid` high at clock edge k appears with `out_valid` high after edge k+6, which is 7 clocks of latency. Frames sent on consecutive clocks come out on consecutive clocks, and none are lost or reordered.
- R2: The latency never exceeds 61 clocks, which is the depth of the unpruned tree for 16 leaves.
- R3: Whenever `out_valid` is high, output bits 0 to 6 and bit 8 are 0.
- R4: The left-branch LLR of a node is the min-sum value sign(a)·sign(b)·min(|a|,|b|), limited to +31. The right-branch LLR is b+a when the returned left partial sum is 0 and b−a when it is 1, saturated to [−32, 31]. Returned partial sums are (left XOR right, right). Each frame's output equals the estimate built from these rules.
- R5: Bit 7 is 1 exactly when the exact, unsaturated sum of the four LLRs that enter the repetition subtree is negative.
- R6: The parity-check subtree takes hard decisions. If their parity is odd, it flips the decision with the smallest magnitude, and the lowest index wins a tie. Bits 9 to 11 are the polar transform of the resulting word.
- R7: The all-data subtree takes hard decisions of its four LLRs, with 0 for a non-negative LLR. Bits 12 to 15 are the polar transform of those decisions.
- R8: All-saturated frames (every LLR −32, or every LLR +31) decode by the same rules without wrap-around.
- R9: While reset is asserted, and for the clocks after it until the first frame arrives, `out_valid` is 0 and `out_bits` is 0.
- R10: While `out_valid` is low, `out_bits` keeps the last decoded word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Frame on `in_llr` is taken at this edge |
| in_llr | input | 96 | Sixteen signed 6-bit channel LLRs, LLR i at bits 6i+5..6i |
| out_valid | output | 1 | `out_bits` holds a newly decoded frame |
| out_bits | output | 16 | Estimated source bits, bit i is leaf i |

## Verification
The bound properties assume only that `in_valid` is a known value on every edge after reset is released. They also assume that no frame is offered while reset is low. The LLR payload may take any 6-bit value, including −32. The bench drives `in_valid` low through reset and drives it away from the clock edge. Its payloads cover noisy encoded frames, raw uniform LLRs and fully saturated frames, so that both the saturating and the tie-breaking paths are reached.

// File: rtl/polar_sc_pipe.sv
module polar_sc_pipe #(
  parameter int W = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [16*W-1:0] in_llr,
  output logic            out_valid,
  output logic [15:0]     out_bits
);
  localparam int N  = 16;
  localparam int H  = N / 2;
  localparam int Q  = N / 4;
  localparam int HI = 2 ** (W - 1) - 1;

  typedef logic signed [W-1:0] llr_t;
  typedef logic signed [W+1:0] wide_t;

  function automatic llr_t clip(input wide_t x);
    if (x > wide_t'(HI)) return llr_t'(HI);
    if (x < -wide_t'(HI) - 1) return llr_t'(-HI - 1);
    return x[W-1:0];
  endfunction

  function automatic logic [W-1:0] mag(input llr_t a);
    logic [W-1:0] n;
    n = ~a + 1'b1;
    return a[W-1] ? n : a;
  endfunction

  function automatic llr_t fmin(input llr_t a, input llr_t b);
    logic [W-1:0] ma, mb, m, nm;
    ma = mag(a);
    mb = mag(b);
    m  = (ma < mb) ? ma : mb;
    nm = ~m + 1'b1;
    if (a[W-1] ^ b[W-1]) return nm;
    if (m > W'(HI)) return llr_t'(HI);
    return m;
  endfunction

  function automatic llr_t gsum(input llr_t a, input llr_t b, input logic u);
    wide_t ea, eb;
    ea = a;
    eb = b;
    return clip(u ? eb - ea : eb + ea);
  endfunction

  logic [5:0] vld;
  llr_t ch1 [N], ch2 [N], ch3 [N];
  llr_t a1 [H];
  llr_t a2 [Q];
  llr_t a4 [H], a5 [H], a6 [H];
  llr_t b5 [Q];
  logic r3, r4, r5, r6;
  logic [Q-1:0] spc6;

  logic rep_neg;
  always_comb begin
    wide_t acc;
    acc = '0;
    for (int i = 0; i < Q; i++) acc = acc + wide_t'(a2[i]);
    rep_neg = acc[W+1];
  end

  logic [Q-1:0] spc_fix;
  always_comb begin
    logic [Q-1:0] hd;
    logic [W-1:0] bm;
    logic [1:0]   best;
    for (int i = 0; i < Q; i++) hd[i] = b5[i][W-1];
    bm   = mag(b5[0]);
    best = 2'd0;
    for (int i = 1; i < Q; i++) begin
      if (mag(b5[i]) < bm) begin
        bm   = mag(b5[i]);
        best = 2'(i);
      end
    end
    spc_fix = hd ^ ((^hd) ? (4'b0001 << best) : 4'b0000);
  end

  logic [Q-1:0] hr;
  always_comb begin
    llr_t e;
    for (int i = 0; i < Q; i++) begin
      e     = gsum(a6[i], a6[i+Q], spc6[i]);
      hr[i] = e[W-1];
    end
  end

  wire [15:0] ubits = {hr[3], hr[2] ^ hr[3], hr[1] ^ hr[3], ^hr,
                       spc6[3], spc6[2] ^ spc6[3], spc6[1] ^ spc6[3], ^spc6,
                       r6, 7'b0};

  always_ff @(posedge clk) begin
    for (int i = 0; i < N; i++) ch1[i] <= in_llr[i*W +: W];
    for (int i = 0; i < H; i++)
      a1[i] <= fmin(llr_t'(in_llr[i*W +: W]), llr_t'(in_llr[(i+H)*W +: W]));
    ch2 <= ch1;
    for (int i = 0; i < Q; i++) a2[i] <= gsum(a1[i], a1[i+Q], 1'b0);
    ch3 <= ch2;
    r3  <= rep_neg;
    for (int i = 0; i < H; i++) a4[i] <= gsum(ch3[i], ch3[i+H], r3);
    r4 <= r3;
    for (int i = 0; i < Q; i++) b5[i] <= fmin(a4[i], a4[i+Q]);
    a5 <= a4;
    r5 <= r4;
    spc6 <= spc_fix;
    a6   <= a5;
    r6   <= r5;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld       <= '0;
      out_valid <= 1'b0;
      out_bits  <= '0;
    end else begin
      vld       <= {vld[4:0], in_valid};
      out_valid <= vld[5];
      if (vld[5]) out_bits <= ubits;
    end
  end
endmodule

// File: rtl/polar_sc_pipe_chk.sv
module polar_sc_pipe_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        out_valid,
  input logic [15:0] out_bits
);
  localparam logic [15:0] FROZEN = 16'h017F;
  logic [2:0] since;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) since <= '0;
    else if (since != 3'd7) since <= since + 3'd1;
  end

  AST_LATENCY_SEVEN: assert property (@(posedge clk) disable iff (!rst_n)
    (since == 3'd7) |-> (out_valid == $past(in_valid, 7))); // R1
  AST_FROZEN_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((out_bits & FROZEN) == 16'h0)); // R3
  AST_QUIET_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    (since != 3'd7) |-> !out_valid); // R9
  AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (since != 3'd0 && !out_valid) |-> $stable(out_bits)); // R10
endmodule

bind polar_sc_pipe polar_sc_pipe_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
  .out_valid(out_valid), .out_bits(out_bits)
);

// File: tb/sim_polar_sc_pipe.sv
module sim_polar_sc_pipe;
  localparam int CLK_PERIOD = 10;
  localparam int W = 6;

  logic clk = 0, rst_n = 0, in_valid = 0;
  logic [16*W-1:0] in_llr = '0;
  logic out_valid;
  logic [15:0] out_bits;

  polar_sc_pipe #(.W(W)) u0 (.clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .in_llr(in_llr), .out_valid(out_valid), .out_bits(out_bits));

  always #(CLK_PERIOD/2) clk = ~clk;

  int nchk = 0, nfail = 0, cyc = 0, wp = 0, rp = 0, got = 0, sent = 0;
  logic [15:0] expq [1024];
  logic [15:0] last_seen = '0;

  always @(posedge clk) cyc++;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int sat(input int x);
    return x > 31 ? 31 : (x < -32 ? -32 : x);
  endfunction
  function automatic int iabs(input int x);
    return x < 0 ? -x : x;
  endfunction
  function automatic int fm(input int a, input int b);
    int m;
    m = iabs(a) < iabs(b) ? iabs(a) : iabs(b);
    return sat(((a < 0) != (b < 0)) ? -m : m);
  endfunction
  function automatic int gm(input int a, input int b, input logic u);
    return sat(u ? b - a : b + a);
  endfunction
  function automatic logic [15:0] xform(input logic [15:0] v);
    for (int s = 1; s < 16; s = s * 2)
      for (int i = 0; i < 16; i++)
        if ((i & s) == 0) v[i] = v[i] ^ v[i+s];
    return v;
  endfunction

  function automatic logic [15:0] model(input int ch[16]);
    int a[8], b[4], c[8], d[4], e[4], s, mn, mi;
    logic r;
    logic [3:0] p, h;
    logic [15:0] x;
    for (int i = 0; i < 8; i++) a[i] = fm(ch[i], ch[i+8]);
    for (int i = 0; i < 4; i++) b[i] = sat(a[i] + a[i+4]);
    s = 0;
    for (int i = 0; i < 4; i++) s += b[i];
    r = (s < 0);
    for (int i = 0; i < 8; i++) c[i] = gm(ch[i], ch[i+8], r);
    for (int i = 0; i < 4; i++) d[i] = fm(c[i], c[i+4]);
    mn = 1000; mi = 0;
    for (int i = 0; i < 4; i++) begin
      p[i] = (d[i] < 0);
      if (iabs(d[i]) < mn) begin mn = iabs(d[i]); mi = i; end
    end
    if (^p) p[mi] = ~p[mi];
    for (int i = 0; i < 4; i++) begin
      e[i] = gm(c[i], c[i+4], p[i]);
      h[i] = (e[i] < 0);
    end
    for (int i = 0; i < 4; i++) begin
      x[i+8]  = p[i] ^ h[i];
      x[i+12] = h[i];
      x[i]    = r ^ p[i] ^ h[i];
      x[i+4]  = r ^ h[i];
    end
    return xform(x);
  endfunction

  task automatic send(input int l[16]);
    for (int i = 0; i < 16; i++) in_llr[i*W +: W] = W'(l[i]);
    in_valid = 1'b1;
    expq[wp] = model(l);
    wp++;
    sent++;
    @(negedge clk);
  endtask

  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      logic [15:0] e;
      e = expq[rp];
      rp++;
      got++;
      chk((out_bits & 16'h017F) == (e & 16'h017F), "R3 frozen bits", out_bits, e);
      chk(out_bits[7] == e[7], "R5 repetition bit", out_bits, e);
      chk((out_bits & 16'h0E00) == (e & 16'h0E00), "R6 parity-check bits", out_bits, e);
      chk((out_bits & 16'hF000) == (e & 16'hF000), "R7 data-subtree bits", out_bits, e);
      chk(out_bits == e, "R4 whole frame", out_bits, e);
      last_seen = out_bits;
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    nfail++;
    $display("FAIL R1 watchdog expired actual=%0d expected=%0d", got, sent);
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    int l[16];
    int t0, lat, amp;
    logic [15:0] u, x;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R9 valid in reset", out_valid, 0);
    chk(out_bits == 16'h0, "R9 bits in reset", out_bits, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R9 valid after reset", out_valid, 0);
    chk(out_bits == 16'h0, "R9 bits after reset", out_bits, 0);

    for (int i = 0; i < 16; i++) l[i] = (i % 3 == 0) ? -7 : 5;
    t0 = cyc;
    send(l);
    in_valid = 1'b0;
    while (!out_valid && cyc - t0 < 100) @(negedge clk);
    lat = cyc - t0;
    chk(lat == 7, "R1 latency", lat, 7);
    chk(lat <= 61, "R2 latency bound", lat, 61);

    for (int k = 0; k < 6; k++) begin
      for (int i = 0; i < 16; i++)
        case (k)
          0: l[i] = 0;
          1: l[i] = 31;
          2: l[i] = -32;
          3: l[i] = (i % 2) ? -32 : 31;
          4: l[i] = (i < 8) ? 3 : -3;
          default: l[i] = (i == 5 || i == 13) ? -1 : 1;
        endcase
      send(l);
      in_valid = 1'b0;
      repeat (2) @(negedge clk);
    end
    repeat (10) @(negedge clk);
    chk(got == sent, "R8 saturated frames delivered", got, sent);

    for (int n = 0; n < 400; n++) begin
      if (n % 2 == 0) begin
        u = 16'($urandom) & 16'hFE80;
        x = xform(u);
        amp = int'($urandom_range(12, 2));
        for (int i = 0; i < 16; i++)
          l[i] = sat((x[i] ? -amp : amp) + int'($urandom_range(20)) - 10);
      end else begin
        for (int i = 0; i < 16; i++) l[i] = int'($urandom_range(63)) - 32;
      end
      send(l);
      if (n >= 200 && $urandom_range(3) == 0) begin
        in_valid = 1'b0;
        @(negedge clk);
      end
    end
    in_valid = 1'b0;
    repeat (12) @(negedge clk);
    chk(got == sent, "R1 frames delivered in order", got, sent);

    for (int k = 0; k < 5; k++) begin
      chk(out_valid == 1'b0, "R10 idle valid", out_valid, 0);
      chk(out_bits == last_seen, "R10 bits held", out_bits, last_seen);
      @(negedge clk);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule